// File: doc/BRIEF.md
# UART Register Front End

This block sits between a 32-bit memory-mapped slave bus and a pair of serial engines: a receiver that hands over each byte with a one-cycle strobe and its error flags, and a transmitter that takes a byte through a strobe/busy handshake. Software sees three registers. The first holds the line setup word that both engines use. The second returns the last received byte with its status. The third accepts bytes to send, controls the break state of the line, and reports line status.

The receive register shows whether it holds fresh data through the bits above the byte. A value with all of those bits clear is a valid, error-free byte, so a poller needs a single compare. Reading the register consumes the byte. The transmit side holds one word, so a write is never lost while the engine is busy. Two interrupt lines, one for "byte waiting" and one for "transmitter idle", let software work without polling.

Top module: `uart_regs`

## Requirements
- R1: Every access with `stb_i` high is acknowledged by `ack_o` high on the next clock only. `stall_o` is always 0. `stb_i` alone qualifies an access.
- R2: After reset the following hold. `ack_o` is 0 and `rx_int_o` is 0. `tx_int_o` is 1 and `tx_stb_o` is 0. `tx_brk_o` is 0. `setup_o` equals `SETUP_INIT`. The receive register reads 0x100.
- R3: Address 0 is the setup register. A write stores bits [29:0], and a read returns them with bits [31:30] as 0. Address 1 reads 0, and writes to it change nothing.
- R4: A read of the receive register (address 2) returns the following. Bits [7:0] are the byte. Bit 8 is 1 when no unread byte is held. Bit 9 is the parity error and bit 10 is the frame error. Bit 11 is the break flag, and bits [31:12] are 0.
- R5: A receive strobe sets `rx_int_o` and loads the byte with its three flags. Any read of address 2 clears `rx_int_o` and the flags and sets bit 8. The byte itself is kept.
- R6: A transmit write with bit 9 clear, outside break, loads the byte into a one-word buffer. `tx_stb_o` is then high from the next clock with `tx_data_o` equal to the byte, until the engine accepts it (strobe high and `tx_busy_i` low). A later write before acceptance replaces the buffered byte.
- R7: A transmit write with bit 9 set raises `tx_brk_o`. A transmit write with bit 9 clear while in break drops `tx_brk_o` and queues nothing.
- R8: A read of the transmit register (address 3) returns the following. Bits [7:0] are the last buffered byte. Bit 8 is busy, meaning the engine is busy or a byte is buffered. Bit 9 is break, bit 10 is `tx_line_i` and bit 11 is `rx_line_i`. `tx_int_o` is the inverse of bit 8.
- R9: Writes to address 2 have no effect. A byte that arrives before the previous one is read replaces it.
- R10: `setup_o` takes a new setup value at the same clock edge that acknowledges the write.
- R11: When a receive strobe and a read of address 2 occur in the same clock, the read returns the old contents. The new byte stays pending, with `rx_int_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stb_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register select |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Access acknowledge |
| stall_o | output | 1 | Always 0 |
| rdata_o | output | 32 | Read data, valid with ack_o |
| setup_o | output | 30 | Line setup word to both engines |
| rx_stb_i | input | 1 | Receiver byte strobe |
| rx_data_i | input | 8 | Received byte |
| rx_perr_i | input | 1 | Parity error of this byte |
| rx_ferr_i | input | 1 | Frame error of this byte |
| rx_brk_i | input | 1 | Receiver sees break |
| rx_line_i | input | 1 | Synchronized receive line level |
| tx_stb_o | output | 1 | Transmit request to engine |
| tx_data_o | output | 8 | Byte to transmit |
| tx_brk_o | output | 1 | Hold line in break |
| tx_busy_i | input | 1 | Transmit engine busy |
| tx_line_i | input | 1 | Current transmit line level |
| rx_int_o | output | 1 | Byte waiting |
| tx_int_o | output | 1 | Transmitter idle |

## Verification
A receive strobe and a software read of the receive register can land on the same clock edge. Which of the two wins decides whether a byte is lost. The bench drives both in one cycle and checks the outcome in two steps. The read first returns the older byte, and the interrupt stays high. A second read then returns the new byte. The same question arises on the transmit side, where a second write can arrive while the engine is still busy with the first byte. The bench's engine model records every byte it accepts, which shows that the buffered byte is delivered once the engine goes idle.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_SETUP = 2'b00,
    REG_SPARE = 2'b01,
    REG_RXD   = 2'b10,
    REG_TXD   = 2'b11
  } reg_sel_e;

  // bit positions decoded by software
  localparam int unsigned RX_NV_BIT   = 8;
  localparam int unsigned RX_PERR_BIT = 9;
  localparam int unsigned RX_FERR_BIT = 10;
  localparam int unsigned RX_BRK_BIT  = 11;
  localparam int unsigned TX_BUSY_BIT = 8;
  localparam int unsigned TX_BRK_BIT  = 9;
  localparam int unsigned TX_TLN_BIT  = 10;
  localparam int unsigned TX_RLN_BIT  = 11;
  localparam int unsigned STAT_TOP    = 11;
endpackage

// File: rtl/uart_bus_if.sv
module uart_bus_if
  import uart_regs_pkg::*;
#(
  parameter int unsigned SETUP_W = 30,
  parameter logic [SETUP_W-1:0] SETUP_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [BUS_W-1:0]  rx_word_i,
  input  logic [BUS_W-1:0]  tx_word_i,
  output logic              ack_o,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [SETUP_W-1:0] setup_o,
  output logic              rx_rd_o,
  output logic              tx_wr_o
);
  localparam int unsigned PAD_W = BUS_W - SETUP_W;

  reg_sel_e         sel;
  logic             setup_wr;
  logic [BUS_W-1:0] rd_mux;
  logic             unused_wtop;

  assign sel         = reg_sel_e'(addr_i);
  assign unused_wtop = ^wdata_i[BUS_W-1:SETUP_W];

  always_comb begin
    setup_wr = stb_i && we_i && (sel == REG_SETUP);
    tx_wr_o  = stb_i && we_i && (sel == REG_TXD);
    rx_rd_o  = stb_i && !we_i && (sel == REG_RXD);
  end

  always_comb begin
    unique case (sel)
      REG_SETUP: rd_mux = {{PAD_W{1'b0}}, setup_o};
      REG_RXD:   rd_mux = rx_word_i;
      REG_TXD:   rd_mux = tx_word_i;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      rdata_o <= '0;
      setup_o <= SETUP_INIT;
    end else begin
      ack_o <= stb_i;
      if (stb_i && !we_i) rdata_o <= rd_mux;
      if (setup_wr) setup_o <= wdata_i[SETUP_W-1:0];
    end
  end
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_stb_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_perr_i,
  input  logic              rx_ferr_i,
  input  logic              rx_brk_i,
  input  logic              rd_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              brk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o  <= '0;
      valid_o <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
      brk_o   <= 1'b0;
    end else if (rx_stb_i) begin
      // arrival wins over a read in the same cycle
      byte_o  <= rx_data_i;
      valid_o <= 1'b1;
      perr_o  <= rx_perr_i;
      ferr_o  <= rx_ferr_i;
      brk_o   <= rx_brk_i;
    end else if (rd_i) begin
      valid_o <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
      brk_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              wr_brk_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  input  logic              eng_busy_i,
  output logic              stb_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              brk_o,
  output logic              busy_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      data_o <= '0;
      brk_o  <= 1'b0;
    end else begin
      if (pend_q && !eng_busy_i) pend_q <= 1'b0;
      if (wr_i) begin
        if (wr_brk_i) begin
          brk_o <= 1'b1;
        end else if (brk_o) begin
          brk_o <= 1'b0;
        end else begin
          pend_q <= 1'b1;
          data_o <= wr_byte_i;
        end
      end
    end
  end

  assign stb_o  = pend_q;
  assign busy_o = pend_q | eng_busy_i;
endmodule

// File: rtl/uart_regs.sv
module uart_regs
  import uart_regs_pkg::*;
#(
  parameter int unsigned SETUP_W = 30,
  parameter logic [SETUP_W-1:0] SETUP_INIT = 30'd868
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stb_i,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic               ack_o,
  output logic               stall_o,
  output logic [31:0]        rdata_o,
  output logic [SETUP_W-1:0] setup_o,
  input  logic               rx_stb_i,
  input  logic [7:0]         rx_data_i,
  input  logic               rx_perr_i,
  input  logic               rx_ferr_i,
  input  logic               rx_brk_i,
  input  logic               rx_line_i,
  output logic               tx_stb_o,
  output logic [7:0]         tx_data_o,
  output logic               tx_brk_o,
  input  logic               tx_busy_i,
  input  logic               tx_line_i,
  output logic               rx_int_o,
  output logic               tx_int_o
);
  localparam int unsigned HI_W = BUS_W - STAT_TOP - 1;

  logic              rx_rd, tx_wr;
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_valid, rx_perr, rx_ferr, rx_brk;
  logic              tx_busy;
  logic [BUS_W-1:0]  rx_word, tx_word;

  assign rx_word = {{HI_W{1'b0}}, rx_brk, rx_ferr, rx_perr, ~rx_valid, rx_byte};
  assign tx_word = {{HI_W{1'b0}}, rx_line_i, tx_line_i, tx_brk_o, tx_busy, tx_data_o};

  uart_bus_if #(.SETUP_W(SETUP_W), .SETUP_INIT(SETUP_INIT)) u_bus (
    .clk_i, .rst_ni, .stb_i, .we_i, .addr_i, .wdata_i,
    .rx_word_i (rx_word),
    .tx_word_i (tx_word),
    .ack_o, .rdata_o, .setup_o,
    .rx_rd_o   (rx_rd),
    .tx_wr_o   (tx_wr)
  );

  uart_rx_hold u_rx (
    .clk_i, .rst_ni, .rx_stb_i, .rx_data_i, .rx_perr_i, .rx_ferr_i, .rx_brk_i,
    .rd_i    (rx_rd),
    .byte_o  (rx_byte),
    .valid_o (rx_valid),
    .perr_o  (rx_perr),
    .ferr_o  (rx_ferr),
    .brk_o   (rx_brk)
  );

  uart_tx_hold u_tx (
    .clk_i, .rst_ni,
    .wr_i       (tx_wr),
    .wr_brk_i   (wdata_i[TX_BRK_BIT]),
    .wr_byte_i  (wdata_i[BYTE_W-1:0]),
    .eng_busy_i (tx_busy_i),
    .stb_o      (tx_stb_o),
    .data_o     (tx_data_o),
    .brk_o      (tx_brk_o),
    .busy_o     (tx_busy)
  );

  assign stall_o  = 1'b0;
  assign rx_int_o = rx_valid;
  assign tx_int_o = ~tx_busy;
endmodule

// File: rtl/uart_regs_chk.sv
module uart_regs_chk #(
  parameter int unsigned SETUP_W = 30
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               stb_i,
  input logic               we_i,
  input logic [1:0]         addr_i,
  input logic [31:0]        wdata_i,
  input logic               ack_o,
  input logic [SETUP_W-1:0] setup_o,
  input logic               rx_stb_i,
  input logic               rx_int_o,
  input logic               tx_busy_i,
  input logic               tx_stb_o,
  input logic               tx_brk_o,
  input logic               tx_int_o
);
  logic unused_hi;
  assign unused_hi = ^wdata_i[31:SETUP_W];

  AST_ACK_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> ack_o); // R1
  AST_ACK_ONLY_AFTER_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> !ack_o); // R1
  AST_RX_INT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_stb_i |=> rx_int_o); // R5
  AST_RX_INT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !we_i && addr_i == 2'b10 && !rx_stb_i) |=> !rx_int_o); // R5
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_stb_o && tx_busy_i) |=> tx_stb_o); // R6
  AST_BRK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && we_i && addr_i == 2'b11 && wdata_i[9]) |=> tx_brk_o); // R7
  AST_BRK_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && we_i && addr_i == 2'b11 && !wdata_i[9] && tx_brk_o && !tx_stb_o)
    |=> (!tx_brk_o && !tx_stb_o)); // R7
  AST_TX_INT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_int_o |-> (!tx_busy_i && !tx_stb_o)); // R8
  AST_SETUP_SAME_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && we_i && addr_i == 2'b00) |=> setup_o == $past(wdata_i[SETUP_W-1:0])); // R10
  AST_RX_ARRIVAL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_stb_i && stb_i && !we_i && addr_i == 2'b10) |=> rx_int_o); // R11
endmodule

bind uart_regs uart_regs_chk #(.SETUP_W(SETUP_W)) u_chk (.*);

// File: tb/uart_regs_test.sv
`timescale 1ns/1ps
module uart_regs_test;
  localparam int BUSY_LEN = 20;
  localparam int NVEC = 8;
  // {we, addr, wdata, expected read}
  localparam logic [66:0] VEC [NVEC] = '{
    {1'b1, 2'b00, 32'h0000_1234, 32'h0},
    {1'b0, 2'b00, 32'h0,         32'h0000_1234},
    {1'b1, 2'b00, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 2'b00, 32'h0,         32'h3FFF_FFFF},
    {1'b1, 2'b01, 32'h0000_ABCD, 32'h0},
    {1'b0, 2'b01, 32'h0,         32'h0},
    {1'b1, 2'b00, 32'h0123_0456, 32'h0},
    {1'b0, 2'b00, 32'h0,         32'h0123_0456}
  };

  logic clk = 0, rst_n = 0;
  logic stb = 0, we = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0;
  logic ack, stall;
  logic [31:0] rdata;
  logic [29:0] setup;
  logic rx_stb = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0, rx_line = 1, tx_line = 1;
  logic [7:0] rx_data = 0;
  logic tx_stb, tx_brk, rx_int, tx_int;
  logic [7:0] tx_data;
  logic tx_busy;
  int busy_cnt = 0, cap_cnt = 0;
  logic [7:0] cap_last = 0;
  int checks = 0, fails = 0;
  logic [31:0] q;
  int cnt0;

  always #2.5 clk = ~clk;

  uart_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .stb_i(stb), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ack_o(ack), .stall_o(stall), .rdata_o(rdata), .setup_o(setup),
    .rx_stb_i(rx_stb), .rx_data_i(rx_data), .rx_perr_i(rx_perr), .rx_ferr_i(rx_ferr),
    .rx_brk_i(rx_brk), .rx_line_i(rx_line),
    .tx_stb_o(tx_stb), .tx_data_o(tx_data), .tx_brk_o(tx_brk), .tx_busy_i(tx_busy),
    .tx_line_i(tx_line), .rx_int_o(rx_int), .tx_int_o(tx_int)
  );

  // behavioural transmit engine
  assign tx_busy = (busy_cnt != 0);
  always @(posedge clk) begin
    if (tx_stb && !tx_busy) begin
      cap_cnt  <= cap_cnt + 1;
      cap_last <= tx_data;
      busy_cnt <= BUSY_LEN;
    end else if (busy_cnt != 0) begin
      busy_cnt <= busy_cnt - 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [1:0] a, input logic [31:0] d,
                     output logic [31:0] r);
    @(negedge clk);
    stb = 1; we = w; addr = a; wdata = d;
    @(negedge clk);
    stb = 0; we = 0;
    chk("R1 ack", {31'b0, ack}, 32'h1);
    r = rdata;
  endtask

  task automatic rx_byte(input logic [7:0] b, input logic p, input logic f, input logic k);
    @(negedge clk);
    rx_stb = 1; rx_data = b; rx_perr = p; rx_ferr = f; rx_brk = k;
    @(negedge clk);
    rx_stb = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk("R2 ack", {31'b0, ack}, 0);
    chk("R2 rx_int", {31'b0, rx_int}, 0);
    chk("R2 tx_int", {31'b0, tx_int}, 1);
    chk("R2 tx_stb", {31'b0, tx_stb}, 0);
    chk("R2 tx_brk", {31'b0, tx_brk}, 0);
    chk("R2 setup", {2'b0, setup}, 32'd868);
    chk("R1 stall", {31'b0, stall}, 0);
    bus(0, 2'b10, 0, q); chk("R2 rx reg", q, 32'h100);
    bus(0, 2'b11, 0, q); chk("R8 tx reg idle", q, 32'hC00);
    @(negedge clk);
    chk("R1 ack drops", {31'b0, ack}, 0);

    // R3 / R10 vector walk
    for (int i = 0; i < NVEC; i++) begin
      bus(VEC[i][66], VEC[i][65:64], VEC[i][63:32], q);
      if (VEC[i][66]) begin
        if (VEC[i][65:64] == 2'b00) chk("R10 setup_o", {2'b0, setup}, {2'b0, VEC[i][61:32]});
      end else begin
        chk("R3 readback", q, VEC[i][31:0]);
      end
    end

    // R4 / R5 receive
    rx_byte(8'h5A, 0, 0, 0);
    chk("R5 rx_int set", {31'b0, rx_int}, 1);
    bus(0, 2'b10, 0, q); chk("R4 clean byte", q, 32'h05A);
    chk("R5 rx_int clr", {31'b0, rx_int}, 0);
    bus(0, 2'b10, 0, q); chk("R5 consumed", q, 32'h15A);
    rx_byte(8'h3C, 1, 1, 1);
    bus(0, 2'b10, 0, q); chk("R4 error flags", q, 32'hE3C);
    bus(0, 2'b10, 0, q); chk("R5 flags cleared", q, 32'h13C);
    rx_byte(8'h01, 1, 0, 0);
    bus(0, 2'b10, 0, q); chk("R4 parity only", q, 32'h201);

    // R9 overwrite and ignored write
    rx_byte(8'h11, 0, 0, 0);
    rx_byte(8'h66, 0, 0, 0);
    bus(1, 2'b10, 32'hFFFF_FFFF, q);
    chk("R9 write ignored int", {31'b0, rx_int}, 1);
    // R11 arrival and read in one cycle
    @(negedge clk);
    stb = 1; we = 0; addr = 2'b10; rx_stb = 1; rx_data = 8'h77;
    @(negedge clk);
    stb = 0; rx_stb = 0;
    chk("R9 overwrite / R11 old value", rdata, 32'h066);
    chk("R11 int stays", {31'b0, rx_int}, 1);
    bus(0, 2'b10, 0, q); chk("R11 new byte kept", q, 32'h077);

    // R6 transmit
    cnt0 = cap_cnt;
    bus(1, 2'b11, 32'h41, q);
    chk("R6 strobe next clock", {23'b0, tx_stb, tx_data}, 32'h141);
    chk("R8 tx_int low", {31'b0, tx_int}, 0);
    repeat (3) @(negedge clk);
    bus(1, 2'b11, 32'h42, q);
    bus(1, 2'b11, 32'h43, q);
    chk("R6 held while busy", {23'b0, tx_stb, tx_data}, 32'h143);
    bus(0, 2'b11, 0, q); chk("R8 busy bit", q & 32'h1FF, 32'h143);
    repeat (BUSY_LEN * 2 + 10) @(negedge clk);
    chk("R6 engine got both", cap_cnt - cnt0, 2);
    chk("R6 last byte", {24'b0, cap_last}, 32'h43);
    chk("R8 tx_int idle", {31'b0, tx_int}, 1);

    // R7 break
    cnt0 = cap_cnt;
    bus(1, 2'b11, 32'h200, q);
    chk("R7 brk set", {31'b0, tx_brk}, 1);
    bus(0, 2'b11, 0, q); chk("R8 brk bit", q & 32'h300, 32'h200);
    bus(1, 2'b11, 32'h55, q);
    chk("R7 brk clr", {30'b0, tx_brk, tx_stb}, 0);
    repeat (5) @(negedge clk);
    chk("R7 nothing sent", cap_cnt - cnt0, 0);

    // R8 line levels
    tx_line = 0; rx_line = 1;
    bus(0, 2'b11, 0, q); chk("R8 lines a", q & 32'hC00, 32'h800);
    tx_line = 1; rx_line = 0;
    bus(0, 2'b11, 0, q); chk("R8 lines b", q & 32'hC00, 32'h400);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule